// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block sits between a 32-bit register bus and a one-time-programmable fuse array. Software loads a timing word that gives a relax count and a read-strobe count. It then writes the fuse word address into the control register and issues a read command. The sequencer raises busy and waits out a relax interval. It then holds the fuse read strobe for a programmed number of cycles and captures the array's 32-bit output on the last strobe cycle. A second relax interval follows before busy drops.

The control register can be updated in three ways: written whole, bits ORed in through a set alias, or bits cleared through a clear alias. The clear alias is the only way to clear the error flag. A read command issued while a read is running, or while the error flag is set, does not start a read. Instead it raises the error flag and loads the poison word 0xBADABADA into the read-data register. The program-strobe count, the reload bit and the unlock field are stored and read back, but nothing acts on them.

Top module: `fuse_seq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero, including the read-data register, busy (control bit 8) and error (control bit 9), and the fuse strobe is low.
- R2: A write to offset 0x00 loads control bits [6:0] (fuse address), [10] (reload) and [31:16] (unlock field). All other bits read as zero, and the write leaves busy and error unchanged.
- R3: A write to offset 0x04 ORs the written value into bits [6:0], [10] and [31:16]. A write to offset 0x08 clears each of those bits, and the error bit 9, wherever the written value holds a 1.
- R4: Offset 0x10 stores a 22-bit timing word: program strobe in [11:0], relax in [15:12], read strobe in [21:16]. Bits [31:22] read zero. Offset 0x20 stores and returns a full 32-bit word.
- R5: Writing exactly 0x1 to offset 0x30, while idle and with error clear, starts a read. Any other value written there has no effect.
- R6: A read holds fuse_strobe high for (read strobe + 1) cycles, starting after (relax + 1) cycles. fuse_addr carries the address captured at the command and holds it for the whole read, even if the control register changes.
- R7: Busy stays high for exactly 2*(relax+1) + (read strobe+1) cycles per read.
- R8: The fuse data present in the last strobe cycle is loaded into the read-data register at offset 0x40.
- R9: A read command issued while busy or while the error flag is set starts no strobe. It sets error and loads 0xBADABADA into the read-data register.
- R10: A read whose strobe ends while the error flag is set, or in the cycle a command is rejected, leaves 0xBADABADA in the read-data register instead of fuse data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| fuse_addr | output | 7 | Fuse word address |
| fuse_strobe | output | 1 | Fuse read strobe |
| fuse_din | input | 32 | Fuse array output word |

## Verification
Two events can fall on the same clock edge: the capture of fuse data at the end of the strobe, and the rejection of a second read command that raises the error flag. The bench counts edges from an accepted command and issues a second command so that it arrives exactly on the capture edge. The bench passes if, after busy falls, the error flag is set and the read-data register holds the poison word, not the fuse value. The strobe scoreboard must also show only the one pulse from the first command.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

    parameter int FA_W   = 7;
    parameter int DW     = 32;
    parameter int RLX_W  = 4;
    parameter int RSTB_W = 6;
    parameter int PSTB_W = 12;
    parameter int KEY_W  = 16;

    localparam int TIM_W = RSTB_W + RLX_W + PSTB_W;
    localparam int CNT_W = (RSTB_W > RLX_W) ? RSTB_W : RLX_W;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_SET  = 8'h04;
    localparam logic [7:0] OFS_CLR  = 8'h08;
    localparam logic [7:0] OFS_TIM  = 8'h10;
    localparam logic [7:0] OFS_WDAT = 8'h20;
    localparam logic [7:0] OFS_RCTL = 8'h30;
    localparam logic [7:0] OFS_RDAT = 8'h40;

    localparam int BIT_BUSY   = 8;
    localparam int BIT_ERR    = 9;
    localparam int BIT_RELOAD = 10;
    localparam int KEY_LSB    = 16;

    localparam logic [DW-1:0] POISON = 32'hBADA_BADA;
    localparam logic [DW-1:0] RD_GO  = 32'h0000_0001;

    typedef struct packed {
        logic [RSTB_W-1:0] rd_strobe;
        logic [RLX_W-1:0]  relax;
        logic [PSTB_W-1:0] pg_strobe;
    } tim_t;

    typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_STB, PH_POST} phase_t;

    function automatic logic [DW-1:0] pack_ctrl(
        input logic [FA_W-1:0]  addr,
        input logic             busy,
        input logic             err,
        input logic             reload,
        input logic [KEY_W-1:0] key
    );
        logic [DW-1:0] w;
        w = '0;
        w[FA_W-1:0]           = addr;
        w[BIT_BUSY]           = busy;
        w[BIT_ERR]            = err;
        w[BIT_RELOAD]         = reload;
        w[KEY_LSB +: KEY_W]   = key;
        return w;
    endfunction

endpackage

// File: rtl/fuse_ctl_reg.sv
module fuse_ctl_reg
    import fuse_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_full,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [FA_W-1:0]  wd_addr,
    input  logic             wd_reload,
    input  logic [KEY_W-1:0] wd_key,
    input  logic             wd_err,
    input  logic             hw_err,
    output logic [FA_W-1:0]  addr_q,
    output logic             reload_q,
    output logic [KEY_W-1:0] key_q,
    output logic             err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            reload_q <= 1'b0;
            key_q    <= '0;
        end else if (wr_full) begin
            addr_q   <= wd_addr;
            reload_q <= wd_reload;
            key_q    <= wd_key;
        end else if (wr_set) begin
            addr_q   <= addr_q | wd_addr;
            reload_q <= reload_q | wd_reload;
            key_q    <= key_q | wd_key;
        end else if (wr_clr) begin
            addr_q   <= addr_q & ~wd_addr;
            reload_q <= reload_q & ~wd_reload;
            key_q    <= key_q & ~wd_key;
        end
    end

    // error: raised by hardware, lowered only via the clear alias
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (hw_err)
            err_q <= 1'b1;
        else if (wr_clr && wd_err)
            err_q <= 1'b0;
    end

endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [RLX_W-1:0]  relax,
    input  logic [RSTB_W-1:0] rd_strobe,
    output logic              busy,
    output logic              strobe,
    output logic              capture
);

    phase_t            ph;
    logic [CNT_W-1:0]  cnt;
    logic              last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph  <= PH_PRE;
                    cnt <= CNT_W'(relax);
                end
                PH_PRE: if (last) begin
                    ph  <= PH_STB;
                    cnt <= CNT_W'(rd_strobe);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_STB: if (last) begin
                    ph  <= PH_POST;
                    cnt <= CNT_W'(relax);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_POST: if (last) begin
                    ph  <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (ph != PH_IDLE);
    assign strobe  = (ph == PH_STB);
    assign capture = (ph == PH_STB) && last;

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
    import fuse_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr_en,
    input  logic [7:0]      bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [FA_W-1:0] fuse_addr,
    output logic            fuse_strobe,
    input  logic [DW-1:0]   fuse_din
);

    logic wr_full, wr_set, wr_clr, wr_tim, wr_wdat, go;
    logic reject, start;

    logic [FA_W-1:0]  ctl_addr;
    logic             ctl_reload;
    logic [KEY_W-1:0] ctl_key;
    logic             ctl_err;

    logic             seq_busy, seq_capture;
    tim_t             tim_q;
    logic [DW-1:0]    wdat_q;
    logic [DW-1:0]    rdata_q;
    logic [FA_W-1:0]  fa_q;

    assign wr_full = bus_wr_en && (bus_addr == OFS_CTRL);
    assign wr_set  = bus_wr_en && (bus_addr == OFS_SET);
    assign wr_clr  = bus_wr_en && (bus_addr == OFS_CLR);
    assign wr_tim  = bus_wr_en && (bus_addr == OFS_TIM);
    assign wr_wdat = bus_wr_en && (bus_addr == OFS_WDAT);
    assign go      = bus_wr_en && (bus_addr == OFS_RCTL) && (bus_wdata == RD_GO);

    assign reject = go && (seq_busy || ctl_err);
    assign start  = go && !reject;

    fuse_ctl_reg u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr_full   (wr_full),
        .wr_set    (wr_set),
        .wr_clr    (wr_clr),
        .wd_addr   (bus_wdata[FA_W-1:0]),
        .wd_reload (bus_wdata[BIT_RELOAD]),
        .wd_key    (bus_wdata[KEY_LSB +: KEY_W]),
        .wd_err    (bus_wdata[BIT_ERR]),
        .hw_err    (reject),
        .addr_q    (ctl_addr),
        .reload_q  (ctl_reload),
        .key_q     (ctl_key),
        .err_q     (ctl_err)
    );

    fuse_rd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .relax     (tim_q.relax),
        .rd_strobe (tim_q.rd_strobe),
        .busy      (seq_busy),
        .strobe    (fuse_strobe),
        .capture   (seq_capture)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tim_q  <= '0;
            wdat_q <= '0;
            fa_q   <= '0;
        end else begin
            if (wr_tim)  tim_q  <= tim_t'(bus_wdata[TIM_W-1:0]);
            if (wr_wdat) wdat_q <= bus_wdata;
            if (start)   fa_q   <= ctl_addr;
        end
    end

    // poison from a rejected command outranks a capture on the same edge
    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (reject)
            rdata_q <= POISON;
        else if (seq_capture)
            rdata_q <= ctl_err ? POISON : fuse_din;
    end

    assign fuse_addr = fa_q;

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL, OFS_SET, OFS_CLR:
                bus_rdata = pack_ctrl(ctl_addr, seq_busy, ctl_err, ctl_reload, ctl_key);
            OFS_TIM:  bus_rdata = DW'(tim_q);
            OFS_WDAT: bus_rdata = wdat_q;
            OFS_RDAT: bus_rdata = rdata_q;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fuse_seq_chk.sv
module fuse_seq_chk
    import fuse_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            err,
    input logic            strobe,
    input logic [FA_W-1:0] faddr,
    input logic [DW-1:0]   rdata,
    input logic            wr_en,
    input logic [7:0]      addr,
    input logic [DW-1:0]   wdata
);

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !err && wr_en && addr == OFS_RCTL && wdata == RD_GO) |=> busy);

    // R9
    reject_err_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && addr == OFS_RCTL && wdata == RD_GO) |=> err);

    // R3
    err_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CLR && wdata[BIT_ERR]) |=> !err);

    // R6
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> busy);

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(faddr));

    // R10
    poison_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (rdata == POISON));

endmodule

bind fuse_seq_ctrl fuse_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (seq_busy),
    .err    (ctl_err),
    .strobe (fuse_strobe),
    .faddr  (fuse_addr),
    .rdata  (rdata_q),
    .wr_en  (bus_wr_en),
    .addr   (bus_addr),
    .wdata  (bus_wdata)
);

// File: tb/fuse_seq_ctrl_bench.sv
module fuse_seq_ctrl_bench;
    import fuse_seq_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr_en = 1'b0;
    logic [7:0]      bus_addr = 8'h00;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [FA_W-1:0] fuse_addr;
    logic            fuse_strobe;
    logic [DW-1:0]   fuse_din;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_addr_q[$];
    int exp_len_q[$];

    always #5 clk = ~clk;

    fuse_seq_ctrl u_fuse_seq_ctrl (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
        .fuse_strobe(fuse_strobe), .fuse_din(fuse_din)
    );

    function automatic logic [DW-1:0] fuse_word(input logic [FA_W-1:0] a);
        return (32'(a) * 32'h0001_0203) ^ 32'h5A5A_0000;
    endfunction

    assign fuse_din = fuse_strobe ? fuse_word(fuse_addr) : 32'h0F0F_0F0F;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] c;
        n = 0;
        rd(OFS_CTRL, c);
        while (c[BIT_BUSY]) begin
            n++;
            @(posedge clk); #1;
            rd(OFS_CTRL, c);
        end
    endtask

    task automatic push_read(input int a, input int len);
        exp_addr_q.push_back(a);
        exp_len_q.push_back(len);
    endtask

    // monitor: measures each strobe pulse and scores it against the queue
    int  mon_len = 0;
    int  mon_addr = 0;
    bit  mon_prev = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (fuse_strobe) begin
                mon_len++;
                mon_addr = int'(fuse_addr);
            end else if (mon_prev) begin
                if (exp_len_q.size() == 0) begin
                    chk("R9 unexpected strobe", 32'(mon_len), 32'd0);
                end else begin
                    chk("R6 strobe length", 32'(mon_len), 32'(exp_len_q.pop_front()));
                    chk("R6 strobe address", 32'(mon_addr), 32'(exp_addr_q.pop_front()));
                end
                mon_len = 0;
            end
            mon_prev = fuse_strobe;
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int n;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(OFS_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(OFS_TIM, d);  chk("R1 timing", d, 32'h0);
        rd(OFS_WDAT, d); chk("R1 wdata", d, 32'h0);
        rd(OFS_RDAT, d); chk("R1 rdata", d, 32'h0);
        chk("R1 strobe", 32'(fuse_strobe), 32'h0);

        // R2 full control write
        wr(OFS_CTRL, 32'hFFFF_FFFF);
        rd(OFS_CTRL, d); chk("R2 writable bits", d, 32'hFFFF_047F);
        wr(OFS_CTRL, 32'h0000_0300);
        rd(OFS_CTRL, d); chk("R2 busy/err not writable", d, 32'h0);

        // R3 set and clear aliases
        wr(OFS_CTRL, 32'h0000_0005);
        wr(OFS_SET, 32'h0001_0400);
        rd(OFS_CTRL, d); chk("R3 set alias", d, 32'h0001_0405);
        wr(OFS_CLR, 32'h0001_0001);
        rd(OFS_SET, d);  chk("R3 clear alias", d, 32'h0000_0404);
        wr(OFS_CLR, 32'hFFFF_FFFF);
        rd(OFS_CLR, d);  chk("R3 clear all", d, 32'h0);

        // R4 timing and write-data registers
        wr(OFS_TIM, 32'hFFFF_FFFF);
        rd(OFS_TIM, d);  chk("R4 timing width", d, 32'h003F_FFFF);
        wr(OFS_WDAT, 32'h1234_5678);
        rd(OFS_WDAT, d); chk("R4 wdata", d, 32'h1234_5678);

        // R5 non-trigger value ignored
        wr(OFS_RCTL, 32'h0000_0003);
        rd(OFS_CTRL, d); chk("R5 no busy on 0x3", d, 32'h0);
        rd(OFS_RDAT, d); chk("R5 rdata unchanged", d, 32'h0);

        // R7 R8 read A: relax 2, strobe 3
        wr(OFS_TIM, (32'd3 << 16) | (32'd2 << 12));
        wr(OFS_CTRL, 32'h0000_0015);
        push_read(32'h15, 4);
        wr(OFS_RCTL, RD_GO);
        wait_idle(n);
        chk("R7 busy cycles A", 32'(n), 32'd10);
        rd(OFS_RDAT, d); chk("R8 data A", d, fuse_word(7'h15));

        // read B: relax 0, strobe 0
        wr(OFS_TIM, 32'h0);
        wr(OFS_CTRL, 32'h0000_007F);
        push_read(32'h7F, 1);
        wr(OFS_RCTL, RD_GO);
        wait_idle(n);
        chk("R7 busy cycles B", 32'(n), 32'd3);
        rd(OFS_RDAT, d); chk("R8 data B", d, fuse_word(7'h7F));

        // R6 R9 R10 read C: address change and rejected command while busy
        wr(OFS_TIM, (32'd5 << 16) | (32'd1 << 12));
        wr(OFS_CTRL, 32'h0000_002A);
        push_read(32'h2A, 6);
        wr(OFS_RCTL, RD_GO);
        wr(OFS_CTRL, 32'h0000_0001);
        wr(OFS_RCTL, RD_GO);
        rd(OFS_CTRL, d); chk("R9 err after busy trigger", 32'(d[BIT_ERR]), 32'h1);
        rd(OFS_RDAT, d); chk("R9 poison on reject", d, POISON);
        wait_idle(n);
        rd(OFS_RDAT, d); chk("R10 read ends poisoned", d, POISON);

        // R9 command while error set and idle
        wr(OFS_RCTL, RD_GO);
        repeat (12) @(posedge clk); #1;
        rd(OFS_CTRL, d); chk("R9 idle with err: no start", d, 32'h0000_0201);
        wr(OFS_CLR, 32'h0000_0200);
        rd(OFS_CTRL, d); chk("R3 err cleared", d, 32'h0000_0001);

        // R10 collision: rejected command on the capture edge
        wr(OFS_TIM, (32'd2 << 16) | (32'd1 << 12));
        wr(OFS_CTRL, 32'h0000_0033);
        push_read(32'h33, 3);
        wr(OFS_RCTL, RD_GO);
        repeat (4) @(posedge clk); #1;
        wr(OFS_RCTL, RD_GO);
        wait_idle(n);
        rd(OFS_CTRL, d); chk("R10 collision err", 32'(d[BIT_ERR]), 32'h1);
        rd(OFS_RDAT, d); chk("R10 collision poison", d, POISON);

        // recovery read after clearing error
        wr(OFS_CLR, 32'h0000_0200);
        push_read(32'h33, 3);
        wr(OFS_RCTL, RD_GO);
        wait_idle(n);
        chk("R7 busy cycles D", 32'(n), 32'd7);
        rd(OFS_RDAT, d); chk("R8 data after recovery", d, fuse_word(7'h33));

        repeat (3) @(posedge clk); #1;
        chk("R9 no leftover expected strobes", 32'(exp_len_q.size()), 32'd0);
        finish_run();
    end

endmodule